// File: doc/BRIEF.md
# Swappable Redundant Vector Table RAM

This block stores an interrupt vector table in four physical RAM banks, named A, B, C and D. Two of them form the live pair: a primary bank and a redundant shadow copy. The other two form a standby pair with the same structure. The CPU reaches them through four fixed address windows: live primary, live shadow, standby primary and standby shadow.

Software loads the vectors for new firmware into the standby pair while the live pair keeps serving the interrupt controller. A single strobe then exchanges the two pairs within one clock cycle, so the freshly loaded table becomes live at one defined instant.

A write to either primary window is copied into that pair's shadow bank. A read from the live primary window fetches both copies and compares them. A difference raises a one-cycle error pulse and captures the address that was read. A window that names a shadow bank reaches that bank alone, which lets software inspect or repair the shadow copy directly.

Top module: `swap_vector_ram`

## Requirements
- R1: After reset, `rdata`, `swapped`, `mm_err` and `mm_addr` are all zero.
- R2: The four windows are each 0x200 addresses wide. Live primary starts at 0x0000_0D00, live shadow at 0x0100_0D00, standby primary at 0x0100_0900 and standby shadow at 0x0100_0B00. The word index is (addr − window base) >> 1, so address bit 0 is ignored and each bank holds 256 words of 32 bits.
- R3: While `swapped` is 0, the live pair is A (primary) with B (shadow), and the standby pair is C with D. While `swapped` is 1, the live pair is C with D, and the standby pair is A with B.
- R4: A cycle with `swap_req`=1 inverts `swapped` at the next clock edge. A cycle with `swap_req`=0 leaves it unchanged. An access issued in the same cycle as `swap_req` uses the mapping that applied before the swap.
- R5: A write to the live primary window stores the data in both the live primary bank and the live shadow bank.
- R6: A write to the standby primary window stores the data in both the standby primary bank and the standby shadow bank.
- R7: A write to either shadow window changes only that one shadow bank.
- R8: Read data appears on `rdata` one cycle after `rd_en` and holds until the next read. For a primary window, the value returned is the primary bank's word.
- R9: A read from the live primary window whose primary and shadow words differ drives `mm_err` high for exactly the cycle in which the read data appears. In that same cycle, `mm_addr` holds the address that was read. `mm_addr` keeps that value until the next mismatch.
- R10: Reads from the standby primary window and from either shadow window never raise `mm_err`.
- R11: An access outside all four windows writes no bank, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Access address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| swap_req | input | 1 | Pair exchange strobe; each cycle it is high inverts the mapping |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| swapped | output | 1 | 1 while banks C and D form the live pair |
| mm_err | output | 1 | One-cycle pulse on a live primary/shadow mismatch |
| mm_addr | output | 32 | Address of the most recent mismatching read |

## Verification
The assertions check several rules on every cycle:
- the swap flag inverts only on a strobe;
- a primary-window write enables exactly two banks, a shadow-window write exactly one, and an out-of-window access none;
- an error pulse follows only a live primary read and carries that read's address;
- the captured address stays stable between pulses.

Where the data lands, and what comes back, only the bench scenarios can show. These include full-window sweeps before and after each swap, a deliberately corrupted shadow word that moves to the standby side when the pairs exchange, a write issued in the very cycle of a swap, and probes just outside every window edge.

// File: rtl/svr_pkg.sv
package svr_pkg;

    localparam int unsigned NBANKS = 4;

    localparam logic [31:0] LIVE_PRI_BASE = 32'h0000_0D00;
    localparam logic [31:0] LIVE_SHD_BASE = 32'h0100_0D00;
    localparam logic [31:0] STBY_PRI_BASE = 32'h0100_0900;
    localparam logic [31:0] STBY_SHD_BASE = 32'h0100_0B00;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_LIVE_PRI,
        WIN_LIVE_SHD,
        WIN_STBY_PRI,
        WIN_STBY_SHD
    } win_e;

    typedef struct packed {
        logic [NBANKS-1:0] we;      // per-bank write enable
        logic [1:0]        rsel;    // bank whose word is returned
        logic [1:0]        csel;    // bank used for comparison
        logic              cmp;     // compare on this read
        logic              hit;     // address fell in a window
    } route_t;

    // Physical bank number: MSB picks the A/B or C/D pair, LSB picks shadow.
    function automatic logic [1:0] phys_bank(input logic swp, input logic standby,
                                             input logic shadow);
        return {swp ^ standby, shadow};
    endfunction

    function automatic logic in_win(input logic [31:0] a, input logic [31:0] base,
                                    input logic [31:0] span);
        return (a >= base) && ((a - base) < span);
    endfunction

endpackage

// File: rtl/svr_decode.sv
module svr_decode #(
    parameter int unsigned WORDS = 256,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic [31:0]       addr,
    output svr_pkg::win_e     win,
    output logic [IDX_W-1:0]  idx
);
    import svr_pkg::*;

    localparam logic [31:0] SPAN = 32'(2 * WORDS);

    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (in_win(addr, LIVE_PRI_BASE, SPAN)) begin
            win = WIN_LIVE_PRI;
            idx = IDX_W'((addr - LIVE_PRI_BASE) >> 1);
        end else if (in_win(addr, LIVE_SHD_BASE, SPAN)) begin
            win = WIN_LIVE_SHD;
            idx = IDX_W'((addr - LIVE_SHD_BASE) >> 1);
        end else if (in_win(addr, STBY_PRI_BASE, SPAN)) begin
            win = WIN_STBY_PRI;
            idx = IDX_W'((addr - STBY_PRI_BASE) >> 1);
        end else if (in_win(addr, STBY_SHD_BASE, SPAN)) begin
            win = WIN_STBY_SHD;
            idx = IDX_W'((addr - STBY_SHD_BASE) >> 1);
        end
    end

endmodule

// File: rtl/svr_route.sv
module svr_route (
    input  svr_pkg::win_e   win,
    input  logic            swapped,
    input  logic            wr_en,
    input  logic            rd_en,
    output svr_pkg::route_t rt
);
    import svr_pkg::*;

    always_comb begin
        rt      = '0;
        rt.csel = phys_bank(swapped, 1'b0, 1'b1);
        unique case (win)
            WIN_LIVE_PRI: begin
                rt.hit  = 1'b1;
                rt.rsel = phys_bank(swapped, 1'b0, 1'b0);
                rt.cmp  = rd_en;
                if (wr_en) begin
                    rt.we[phys_bank(swapped, 1'b0, 1'b0)] = 1'b1;
                    rt.we[phys_bank(swapped, 1'b0, 1'b1)] = 1'b1;
                end
            end
            WIN_STBY_PRI: begin
                rt.hit  = 1'b1;
                rt.rsel = phys_bank(swapped, 1'b1, 1'b0);
                if (wr_en) begin
                    rt.we[phys_bank(swapped, 1'b1, 1'b0)] = 1'b1;
                    rt.we[phys_bank(swapped, 1'b1, 1'b1)] = 1'b1;
                end
            end
            WIN_LIVE_SHD: begin
                rt.hit  = 1'b1;
                rt.rsel = phys_bank(swapped, 1'b0, 1'b1);
                if (wr_en) rt.we[phys_bank(swapped, 1'b0, 1'b1)] = 1'b1;
            end
            WIN_STBY_SHD: begin
                rt.hit  = 1'b1;
                rt.rsel = phys_bank(swapped, 1'b1, 1'b1);
                if (wr_en) rt.we[phys_bank(swapped, 1'b1, 1'b1)] = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/svr_bank.sv
module svr_bank #(
    parameter int unsigned WORDS  = 256,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/swap_vector_ram.sv
module swap_vector_ram #(
    parameter int unsigned WORDS  = 256,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              swap_req,
    output logic [DATA_W-1:0] rdata,
    output logic              swapped,
    output logic              mm_err,
    output logic [31:0]       mm_addr
);
    import svr_pkg::*;

    win_e              win;
    logic [IDX_W-1:0]  idx;
    route_t            rt;
    logic [DATA_W-1:0] bank_rd [NBANKS];
    logic [DATA_W-1:0] pri_word;
    logic [DATA_W-1:0] shd_word;

    svr_decode #(.WORDS(WORDS)) dec_i (
        .addr (addr),
        .win  (win),
        .idx  (idx)
    );

    svr_route route_i (
        .win     (win),
        .swapped (swapped),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rt      (rt)
    );

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        svr_bank #(.WORDS(WORDS), .DATA_W(DATA_W)) bank_i (
            .clk   (clk),
            .we    (rt.we[g]),
            .idx   (idx),
            .wdata (wdata),
            .rdata (bank_rd[g])
        );
    end

    assign pri_word = bank_rd[rt.rsel];
    assign shd_word = bank_rd[rt.csel];

    always_ff @(posedge clk) begin
        if (rst) begin
            swapped <= 1'b0;
            rdata   <= '0;
            mm_err  <= 1'b0;
            mm_addr <= '0;
        end else begin
            swapped <= swapped ^ swap_req;
            mm_err  <= 1'b0;
            if (rd_en) begin
                rdata <= rt.hit ? pri_word : '0;
                if (rt.cmp && (pri_word != shd_word)) begin
                    mm_err  <= 1'b1;
                    mm_addr <= addr;
                end
            end
        end
    end

    AST_SWAP_FLIP: assert property (@(posedge clk) disable iff (rst)
        swap_req |=> (swapped != $past(swapped)));                          // R4
    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !swap_req |=> $stable(swapped));                                    // R4
    AST_PRI_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (win == WIN_LIVE_PRI || win == WIN_STBY_PRI))
            |-> ($countones(rt.we) == 2));                                  // R5 R6
    AST_SHD_SOLO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (win == WIN_LIVE_SHD || win == WIN_STBY_SHD))
            |-> ($countones(rt.we) == 1));                                  // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (win == WIN_NONE) |-> (rt.we == '0));                               // R11
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win == WIN_NONE) |=> (rdata == '0));                      // R11
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        mm_err |-> ($past(rd_en) && $past(win) == WIN_LIVE_PRI));           // R10
    AST_ERR_ADDR: assert property (@(posedge clk) disable iff (rst)
        mm_err |-> (mm_addr == $past(addr)));                               // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mm_err |-> $stable(mm_addr));                                      // R9

endmodule

// File: tb/swap_vector_ram_tb_top.sv
`timescale 1ns/1ps
module swap_vector_ram_tb_top;

    localparam logic [31:0] LP = 32'h0000_0D00;
    localparam logic [31:0] LS = 32'h0100_0D00;
    localparam logic [31:0] SP = 32'h0100_0900;
    localparam logic [31:0] SS = 32'h0100_0B00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        swap_req = 1'b0;
    logic [31:0] rdata;
    logic        swapped;
    logic        mm_err;
    logic [31:0] mm_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    swap_vector_ram dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .swap_req(swap_req), .rdata(rdata), .swapped(swapped),
        .mm_err(mm_err), .mm_addr(mm_addr)
    );

    function automatic logic [31:0] pa(input int i);
        return 32'hA000_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    function automatic logic [31:0] pc(input int i);
        return 32'hC000_0000 ^ (32'(i) * 32'h0101_0101);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic swp);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; swap_req = swp;
        @(negedge clk);
        wr_en = 1'b0; swap_req = 1'b0;
    endtask

    task automatic rd(input string req, input logic [31:0] a, input logic [31:0] exp,
                      input logic exp_err);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, exp);
        chk({req, " err"}, 32'(mm_err), 32'(exp_err));
    endtask

    task automatic pulse_swap(input int cycles);
        @(negedge clk);
        swap_req = 1'b1;
        repeat (cycles) @(negedge clk);
        swap_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        chk("R1 rdata", rdata, 32'h0);
        chk("R1 swapped", 32'(swapped), 32'h0);
        chk("R1 mm_err", 32'(mm_err), 32'h0);
        chk("R1 mm_addr", mm_addr, 32'h0);

        // R2 R5: fill live primary, odd addresses on odd words test bit 0 ignored
        for (int i = 0; i < 256; i++) wr(LP + 32'(2 * i) + 32'(i & 1), pa(i), 1'b0);
        for (int i = 0; i < 256; i++) rd("R5 live shadow mirror", LS + 32'(2 * i), pa(i), 1'b0);
        // R6: fill standby primary, check the standby shadow copy
        for (int i = 0; i < 256; i++) wr(SP + 32'(2 * i), pc(i), 1'b0);
        for (int i = 0; i < 256; i++) rd("R6 standby shadow mirror", SS + 32'(2 * i), pc(i), 1'b0);
        // R3 R8: live primary still A, no mismatch
        for (int i = 0; i < 256; i++) rd("R3 R8 live primary", LP + 32'(2 * i), pa(i), 1'b0);

        // R7 R9: corrupt live shadow word 7
        wr(LS + 32'd14, 32'hDEAD_0007, 1'b0);
        rd("R9 mismatch read", LP + 32'd15, pa(7), 1'b1);
        chk("R9 captured addr", mm_addr, LP + 32'd15);
        @(negedge clk);
        chk("R9 pulse ends", 32'(mm_err), 32'h0);
        rd("R7 standby primary untouched", SP + 32'd14, pc(7), 1'b0);
        rd("R7 standby shadow untouched", SS + 32'd14, pc(7), 1'b0);
        rd("R10 live shadow read no compare", LS + 32'd14, 32'hDEAD_0007, 1'b0);
        rd("R9 clean read", LP + 32'd16, pa(8), 1'b0);
        chk("R9 addr held", mm_addr, LP + 32'd15);
        // R7 R10: corrupt standby shadow word 9
        wr(SS + 32'd18, 32'hBEEF_0009, 1'b0);
        rd("R10 standby primary no compare", SP + 32'd18, pc(9), 1'b0);
        rd("R7 standby shadow value", SS + 32'd18, 32'hBEEF_0009, 1'b0);
        rd("R7 live primary untouched", LP + 32'd18, pa(9), 1'b0);

        // R11: out-of-window probes
        wr(32'h0000_0CFF, 32'hFFFF_FFFF, 1'b0);
        wr(32'h0000_0F00, 32'hFFFF_FFFF, 1'b0);
        wr(32'h0100_08FF, 32'hFFFF_FFFF, 1'b0);
        wr(32'h0100_0F00, 32'hFFFF_FFFF, 1'b0);
        wr(32'h0000_0900, 32'hFFFF_FFFF, 1'b0);
        rd("R11 below live primary", 32'h0000_0CFF, 32'h0, 1'b0);
        rd("R11 above live primary", 32'h0000_0F00, 32'h0, 1'b0);
        rd("R11 below standby primary", 32'h0100_08FF, 32'h0, 1'b0);
        rd("R11 above live shadow", 32'h0100_0F00, 32'h0, 1'b0);
        rd("R11 low region gap", 32'h0000_0900, 32'h0, 1'b0);
        rd("R11 R2 live edge 0", LP, pa(0), 1'b0);
        rd("R11 R2 live edge 255", LP + 32'h1FE, pa(255), 1'b0);
        rd("R11 R2 shadow edge 0", LS, pa(0), 1'b0);
        rd("R11 R2 standby edge 255", SP + 32'h1FF, pc(255), 1'b0);
        rd("R11 R2 standby shadow edge 0", SS, pc(0), 1'b0);

        // R4: idle cycles with no strobe keep mapping
        repeat (3) @(negedge clk);
        chk("R4 no strobe", 32'(swapped), 32'h0);
        // R4: swap with a same-cycle write into the old live pair (A/B)
        wr(LP + 32'd6, 32'h5555_0003, 1'b1);
        chk("R4 swapped set", 32'(swapped), 32'h1);
        // R3: live primary is now C, live shadow D (word 9 corrupted)
        for (int i = 0; i < 256; i++)
            rd("R3 swapped live primary", LP + 32'(2 * i), pc(i), i == 9);
        chk("R9 addr after swap", mm_addr, LP + 32'd18);
        for (int i = 0; i < 256; i++)
            rd("R3 R4 swapped standby primary", SP + 32'(2 * i),
               (i == 3) ? 32'h5555_0003 : pa(i), 1'b0);
        rd("R4 old-mapping mirror", SS + 32'd6, 32'h5555_0003, 1'b0);
        rd("R3 corrupted word moved to standby", SS + 32'd14, 32'hDEAD_0007, 1'b0);

        // R4: swap back, then a two-cycle strobe toggles twice
        pulse_swap(1);
        chk("R4 swap back", 32'(swapped), 32'h0);
        rd("R9 mismatch after swap back", LP + 32'd14, pa(7), 1'b1);
        chk("R9 addr updated", mm_addr, LP + 32'd14);
        rd("R4 live word 3", LP + 32'd6, 32'h5555_0003, 1'b0);
        pulse_swap(2);
        chk("R4 double toggle", 32'(swapped), 32'h0);
        rd("R3 unswapped live shadow", LS + 32'd20, pa(10), 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule